// File: doc/BRIEF.md
# Code Histogram Linearity Analyzer

This block measures the static linearity of an analog-to-digital converter from its output codes. While the converter digitizes a slow linear ramp, every code it produces is counted in an internal histogram with one bin per code. An ideal converter gives every code the same share of the samples, so the deviation of each bin from the average is a direct measure of that code's width error. The ramp rate should be set so that each code collects roughly one hundred samples. That gives a resolution of about a hundredth of an LSB.

A stop command starts the analysis pass. The pass leaves out the two over-range bins (code 0 and the full-scale code) and adds up the interior bins. One sequential division then yields a scale factor equal to the inverse of the mean bin count. A final sweep turns each interior count into a differential nonlinearity value. It also keeps a running sum of these values, which gives the integral nonlinearity measured against the endpoint line, and it counts the codes that fall below the missing-code limit. Results are signed fixed-point values with 12 fraction bits. They are read back one code per cycle through an address port.

Top module: `hist_lin_analyzer`

## Requirements
- R1: After reset, busy, done, overflow and miss_count are all 0.
- R2: A clear pulse accepted while idle holds busy high for exactly 2^CODE_W cycles and zeroes every bin. Bin contents are undefined until the first clear.
- R3: A sample on in_valid/in_code is counted only while capturing, which is after an accepted start and up to and including the cycle of stop. Samples at any other time leave every bin unchanged. A start does not clear the bins.
- R4: Every accepted sample adds one to its bin, including samples of the same code on back-to-back cycles.
- R5: A bin count stops at 2^CNT_W-1. A sample that arrives for a full bin sets overflow, which stays set until the next clear.
- R6: Codes 0 and 2^CODE_W-1 read back DNL = 0 and INL = 0, and their counts have no effect on any other result.
- R7: With K = 2^CODE_W-2 interior bins, S the sum of their counts and scale = floor(K·2^24/S), an interior code with count c reports DNL = floor(c·scale/2^12) − 4096, in two's complement with 12 fraction bits.
- R8: DNL and INL are clipped to the 16-bit signed range, so the largest value is 32767. The running INL sum itself is kept without clipping.
- R9: INL of interior code i is the sum of the DNL values of codes 1 through i.
- R10: miss_count equals the number of interior codes whose DNL is below −3686, which is −0.9 LSB.
- R11: done is high for exactly one cycle at the end of the pass, with busy low. After that, rd_addr presented in one cycle gives rd_idx = rd_addr and that code's rd_dnl and rd_inl in the next cycle.
- R12: If no interior sample was counted (S = 0), the scale is 0, so every interior DNL is −4096 and miss_count is K.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Zero all bins (accepted when idle) |
| start | input | 1 | Enter capture (accepted when idle) |
| stop | input | 1 | End capture and run the analysis pass |
| in_valid | input | 1 | Sample qualifier |
| in_code | input | CODE_W | Converter output code |
| rd_addr | input | CODE_W | Result read address |
| rd_idx | output | CODE_W | Code index of the result on rd_dnl/rd_inl |
| rd_dnl | output | OUT_W | DNL of rd_idx, signed, FRAC fraction bits |
| rd_inl | output | OUT_W | INL of rd_idx, signed, FRAC fraction bits |
| miss_count | output | CODE_W | Number of missing codes from the last pass |
| overflow | output | 1 | Sticky bin saturation flag |
| busy | output | 1 | Clear or analysis in progress |
| done | output | 1 | One-cycle pulse at the end of the analysis pass |

## Verification
The hardest situations to reach are a saturated bin and a result large enough to clip. Both need a histogram that is very lopsided, and the default counter width would need tens of thousands of samples to fill one bin. The bench therefore builds the block with 8-bit bins and feeds it long unbroken runs of one code. This fills a bin past its limit and also exercises the update of the same bin on consecutive cycles. In another run, two interior codes carry most of the samples while the rest are nearly empty, which drives one DNL past the clip level and the running INL past its limit before it falls back.

// File: rtl/hla_pkg.sv
package hla_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_CAP,
    ST_DRAIN,
    ST_SUM,
    ST_DIVGO,
    ST_DIVW,
    ST_PASS
  } hla_state_e;
endpackage

// File: rtl/hist_dp_ram.sv
module hist_dp_ram #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hist_restoring_div.sv
module hist_restoring_div #(
  parameter int NUM_W = 28,
  parameter int DEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CW = $clog2(NUM_W + 1);
  localparam int PW = NUM_W + DEN_W;

  logic [NUM_W-1:0] n_q, num_hold;
  logic [DEN_W-1:0] rem_q, d_q;
  logic [CW-1:0]    cnt_q;
  logic             busy_q;
  logic [DEN_W:0]   trial, diff;
  logic             ge;

  assign trial = {rem_q, n_q[NUM_W-1]};
  assign ge    = trial >= {1'b0, d_q};
  assign diff  = trial - {1'b0, d_q};
  assign quo   = n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_q <= '0; num_hold <= '0; rem_q <= '0; d_q <= '0;
      cnt_q <= '0; busy_q <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy_q) begin
        n_q      <= num;
        num_hold <= num;
        d_q      <= den;
        rem_q    <= '0;
        cnt_q    <= CW'(NUM_W);
        busy_q   <= 1'b1;
      end else if (busy_q) begin
        rem_q <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        n_q   <= {n_q[NUM_W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  logic [PW-1:0] qd, nh, dd;
  assign qd = PW'(n_q) * PW'(d_q);
  assign nh = PW'(num_hold);
  assign dd = PW'(d_q);

  // R7
  div_exact_chk: assert property (@(posedge clk) disable iff (rst)
    (done && d_q != '0) |-> (qd <= nh) && ((nh - qd) < dd));
endmodule

// File: rtl/hist_lin_analyzer.sv
module hist_lin_analyzer
  import hla_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 16,
  parameter int OUT_W  = 16,
  parameter int FRAC   = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    start,
  input  logic                    stop,
  input  logic                    in_valid,
  input  logic [CODE_W-1:0]       in_code,
  input  logic [CODE_W-1:0]       rd_addr,
  output logic [CODE_W-1:0]       rd_idx,
  output logic signed [OUT_W-1:0] rd_dnl,
  output logic signed [OUT_W-1:0] rd_inl,
  output logic [CODE_W-1:0]       miss_count,
  output logic                    overflow,
  output logic                    busy,
  output logic                    done
);
  localparam int NB    = 1 << CODE_W;
  localparam int K     = NB - 2;
  localparam int NUM_W = CODE_W + 2 * FRAC;
  localparam int DEN_W = CNT_W + CODE_W;
  localparam int PW    = CNT_W + NUM_W;
  localparam int ACC_W = OUT_W + CODE_W + 1;
  localparam int ONE   = 1 << FRAC;
  localparam int MAXP  = (1 << (OUT_W - 1)) - 1;
  localparam int MISS_TH = (9 * ONE) / 10;
  localparam logic [CODE_W-1:0] LAST    = CODE_W'(NB - 1);
  localparam logic [CODE_W-1:0] LAST_IN = CODE_W'(NB - 2);
  localparam logic [CNT_W-1:0]  CMAX    = '1;
  localparam logic [PW-1:0]     UPLIM   = PW'(MAXP + ONE);
  localparam logic signed [ACC_W-1:0] ACC_HI = ACC_W'(MAXP);
  localparam logic signed [ACC_W-1:0] ACC_LO = -ACC_HI - 1;
  localparam logic signed [OUT_W-1:0] MISS_LIM = OUT_W'(-MISS_TH);

  hla_state_e state_q;
  logic [CODE_W-1:0] idx_q, pidx_q;
  logic              issued_q, rv_q;
  logic [DEN_W-1:0]  sum_q;
  logic [NUM_W-1:0]  scale_q;
  logic signed [ACC_W-1:0] acc_q;

  // ---------------- bin histogram storage ----------------
  logic              bin_we;
  logic [CODE_W-1:0] bin_waddr, bin_raddr;
  logic [CNT_W-1:0]  bin_wdata, bin_rdata;

  hist_dp_ram #(.AW(CODE_W), .DW(CNT_W)) u_bins (
    .clk(clk), .we(bin_we), .waddr(bin_waddr), .wdata(bin_wdata),
    .raddr(bin_raddr), .rdata(bin_rdata)
  );

  // capture pipeline: read in the accept cycle, write one cycle later
  logic              accept, clr_go;
  logic              s1_v_q, wq_v_q;
  logic [CODE_W-1:0] s1_code_q, wq_code_q;
  logic [CNT_W-1:0]  wq_data_q, base, inc;
  logic              bin_full;

  assign accept   = in_valid && (state_q == ST_CAP);
  assign clr_go   = (state_q == ST_IDLE) && clear;
  assign base     = (wq_v_q && wq_code_q == s1_code_q) ? wq_data_q : bin_rdata;
  assign bin_full = (base == CMAX);
  assign inc      = bin_full ? base : base + 1'b1;

  assign bin_raddr = (state_q == ST_CAP) ? in_code : idx_q;
  assign bin_we    = (state_q == ST_CLEAR) || s1_v_q;
  assign bin_waddr = (state_q == ST_CLEAR) ? idx_q : s1_code_q;
  assign bin_wdata = (state_q == ST_CLEAR) ? '0 : inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v_q <= 1'b0; s1_code_q <= '0;
      wq_v_q <= 1'b0; wq_code_q <= '0; wq_data_q <= '0;
      overflow <= 1'b0;
    end else begin
      s1_v_q    <= accept;
      s1_code_q <= in_code;
      wq_v_q    <= s1_v_q;
      wq_code_q <= s1_code_q;
      wq_data_q <= inc;
      if (clr_go) overflow <= 1'b0;
      else if (s1_v_q && bin_full) overflow <= 1'b1;
    end
  end

  // ---------------- scale divider ----------------
  logic             div_go, div_done;
  logic [NUM_W-1:0] div_q;

  assign div_go = (state_q == ST_DIVGO) && (sum_q != '0);

  hist_restoring_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk(clk), .rst(rst), .start(div_go),
    .num(NUM_W'(K) << (2 * FRAC)), .den(sum_q),
    .done(div_done), .quo(div_q)
  );

  // ---------------- per-code normalization ----------------
  logic [PW-1:0]           prod, prod_sh;
  logic signed [OUT_W-1:0] dnl_v, inl_v;
  logic signed [ACC_W-1:0] acc_next;
  logic                    interior, miss_hit;

  assign prod     = PW'(bin_rdata) * PW'(scale_q);
  assign prod_sh  = prod >> FRAC;
  assign interior = (pidx_q != '0) && (pidx_q != LAST);
  assign acc_next = acc_q + ACC_W'(dnl_v);
  assign miss_hit = dnl_v < MISS_LIM;

  always_comb begin
    if (prod_sh > UPLIM) dnl_v = OUT_W'(MAXP);
    else                 dnl_v = prod_sh[OUT_W-1:0] - OUT_W'(ONE);
    if (acc_next > ACC_HI)      inl_v = OUT_W'(MAXP);
    else if (acc_next < ACC_LO) inl_v = OUT_W'(ACC_LO);
    else                        inl_v = acc_next[OUT_W-1:0];
  end

  // ---------------- result storage and read port ----------------
  logic                  res_we;
  logic [2*OUT_W-1:0]    res_wdata, res_rdata;

  assign res_we    = (state_q == ST_PASS) && rv_q;
  assign res_wdata = interior ? {dnl_v, inl_v} : '0;

  hist_dp_ram #(.AW(CODE_W), .DW(2 * OUT_W)) u_res (
    .clk(clk), .we(res_we), .waddr(pidx_q), .wdata(res_wdata),
    .raddr(rd_addr), .rdata(res_rdata)
  );

  assign rd_dnl = res_rdata[2*OUT_W-1:OUT_W];
  assign rd_inl = res_rdata[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) rd_idx <= '0;
    else     rd_idx <= rd_addr;
  end

  // ---------------- control sequence ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE; idx_q <= '0; pidx_q <= '0;
      issued_q <= 1'b0; rv_q <= 1'b0; sum_q <= '0; scale_q <= '0;
      acc_q <= '0; miss_count <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (clear) begin
            state_q <= ST_CLEAR;
            idx_q   <= '0;
          end else if (start) begin
            state_q <= ST_CAP;
          end
        end
        ST_CLEAR: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST) state_q <= ST_IDLE;
        end
        ST_CAP: begin
          if (stop) state_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          idx_q    <= CODE_W'(1);
          sum_q    <= '0;
          rv_q     <= 1'b0;
          issued_q <= 1'b0;
          state_q  <= ST_SUM;
        end
        ST_SUM: begin
          if (!issued_q) begin
            idx_q <= idx_q + 1'b1;
            rv_q  <= 1'b1;
            if (idx_q == LAST_IN) issued_q <= 1'b1;
          end else begin
            rv_q <= 1'b0;
          end
          if (rv_q) sum_q <= sum_q + DEN_W'(bin_rdata);
          if (issued_q && rv_q) state_q <= ST_DIVGO;
        end
        ST_DIVGO: begin
          idx_q      <= '0;
          rv_q       <= 1'b0;
          issued_q   <= 1'b0;
          acc_q      <= '0;
          miss_count <= '0;
          if (sum_q == '0) begin
            scale_q <= '0;
            state_q <= ST_PASS;
          end else begin
            state_q <= ST_DIVW;
          end
        end
        ST_DIVW: begin
          if (div_done) begin
            scale_q <= div_q;
            state_q <= ST_PASS;
          end
        end
        ST_PASS: begin
          if (!issued_q) begin
            idx_q  <= idx_q + 1'b1;
            pidx_q <= idx_q;
            rv_q   <= 1'b1;
            if (idx_q == LAST) issued_q <= 1'b1;
          end else begin
            rv_q <= 1'b0;
          end
          if (rv_q && interior) begin
            acc_q <= acc_next;
            if (miss_hit) miss_count <= miss_count + 1'b1;
          end
          if (rv_q && pidx_q == LAST) begin
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE) && (state_q != ST_CAP);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overflow && !clr_go) |=> overflow);
  // R3
  cap_write_chk: assert property (@(posedge clk) disable iff (rst)
    s1_v_q |-> (state_q == ST_CAP || state_q == ST_DRAIN));
  // R10
  miss_bound_chk: assert property (@(posedge clk) disable iff (rst)
    miss_count <= CODE_W'(K));
endmodule

// File: tb/hist_lin_analyzer_tb.sv
module hist_lin_analyzer_tb;
  localparam int CODE_W = 4;
  localparam int CNT_W  = 8;
  localparam int OUT_W  = 16;
  localparam int FRAC   = 12;
  localparam int NB     = 1 << CODE_W;
  localparam int K      = NB - 2;
  localparam int CMAXI  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clear = 1'b0, start = 1'b0, stop = 1'b0, in_valid = 1'b0;
  logic [CODE_W-1:0] in_code = '0, rd_addr = '0;
  logic [CODE_W-1:0] rd_idx, miss_count;
  logic signed [OUT_W-1:0] rd_dnl, rd_inl;
  logic overflow, busy, done;

  always #2 clk = ~clk;

  hist_lin_analyzer #(.CODE_W(CODE_W), .CNT_W(CNT_W), .OUT_W(OUT_W), .FRAC(FRAC)) u_dut (
    .clk(clk), .rst(rst), .clear(clear), .start(start), .stop(stop),
    .in_valid(in_valid), .in_code(in_code), .rd_addr(rd_addr),
    .rd_idx(rd_idx), .rd_dnl(rd_dnl), .rd_inl(rd_inl),
    .miss_count(miss_count), .overflow(overflow), .busy(busy), .done(done)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cnt_m[NB];
  int exp_dnl[NB];
  int exp_inl[NB];
  int exp_miss;
  bit cap_m = 0;
  bit ovf_m = 0;

  task automatic check(string req, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference: counts, scale, clipping, running sum
  task automatic compute_model();
    longint s = 0, scale, acc = 0, sh, d;
    for (int c = 1; c <= NB - 2; c++) s += cnt_m[c];
    scale = (s == 0) ? 0 : ((longint'(K) << 24) / s);
    exp_miss = 0;
    for (int c = 0; c < NB; c++) begin
      if (c == 0 || c == NB - 1) begin
        exp_dnl[c] = 0; exp_inl[c] = 0;
      end else begin
        sh = (longint'(cnt_m[c]) * scale) >>> 12;
        d  = (sh > 36863) ? 32767 : sh - 4096;
        acc += d;
        exp_dnl[c] = int'(d);
        exp_inl[c] = (acc > 32767) ? 32767 : (acc < -32768) ? -32768 : int'(acc);
        if (d < -3686) exp_miss++;
      end
    end
  endtask

  task automatic send_burst(int code, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_code  = CODE_W'(code);
      if (cap_m) begin
        if (cnt_m[code] < CMAXI) cnt_m[code]++;
        else ovf_m = 1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cap_m = 1;
  endtask

  task automatic do_clear();
    int n = 0;
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    check("R2 clear busy cycles", n, NB);
    for (int c = 0; c < NB; c++) cnt_m[c] = 0;
    ovf_m = 0;
    check("R5 overflow cleared", overflow, 0);
  endtask

  task automatic stop_and_wait();
    int n = 0;
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    cap_m = 0;
    while (!done && n < 2000) begin
      n++;
      @(negedge clk);
    end
    check("R11 done seen", done, 1);
    check("R11 busy low at done", busy, 0);
    compute_model();
    check("R10 missing code count", miss_count, exp_miss);
    check("R5 overflow flag", overflow, ovf_m);
    @(negedge clk);
    check("R11 done one cycle", done, 0);
  endtask

  task automatic sweep(string tag);
    int q[$];
    for (int a = 0; a <= NB; a++) begin
      @(negedge clk);
      if (a > 0) begin
        int e = q.pop_front();
        check("R11 read index", rd_idx, e);
        check(tag, rd_dnl, exp_dnl[e]);
        check("R9 INL running sum", rd_inl, exp_inl[e]);
      end
      if (a < NB) begin
        rd_addr = CODE_W'(a);
        q.push_back(a);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 done after reset", done, 0);
    check("R1 overflow after reset", overflow, 0);
    check("R1 miss_count after reset", miss_count, 0);

    // ramp with uneven counts, heavy end bins (R4 R6 R7)
    do_clear();
    do_start();
    for (int c = 0; c < NB; c++) begin
      int n = (c == 0 || c == NB - 1) ? 60 : 12 + (c * 5) % 7;
      send_burst(c, n);
    end
    stop_and_wait();
    sweep("R7 R4 R6 DNL from counts");

    // samples outside capture are dropped (R3)
    send_burst(4, 20);
    send_burst(9, 7);
    do_start();
    stop_and_wait();
    sweep("R3 DNL unchanged by idle samples");

    // lopsided histogram: clipping and missing codes (R8 R10)
    do_clear();
    do_start();
    send_burst(0, 50);
    send_burst(1, 2); send_burst(2, 2);
    send_burst(3, 250);
    send_burst(4, 100);
    send_burst(9, 1);
    for (int c = 6; c <= NB - 2; c++) if (c != 9) send_burst(c, 2);
    send_burst(NB - 1, 50);
    stop_and_wait();
    sweep("R8 R10 DNL clipped and missing");

    // saturation of a bin, back-to-back same code (R5 R4)
    do_clear();
    do_start();
    send_burst(7, 300);
    send_burst(2, 3);
    send_burst(11, 40);
    stop_and_wait();
    sweep("R5 R4 DNL with saturated bin");
    do_start();
    stop_and_wait();
    check("R5 overflow sticky", overflow, 1);

    // empty histogram (R12)
    do_clear();
    do_start();
    send_burst(0, 10);
    stop_and_wait();
    check("R12 all interior missing", miss_count, K);
    sweep("R12 DNL with empty histogram");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule